// File: doc/BRIEF.md
# Receive Pattern Checker with Hysteretic Link Monitor

This block sits behind a serial receiver that has already been deserialized and word-aligned. Each valid parallel word is compared, bit for bit, against a locally built copy of the test pattern picked on `pat_sel`. The picked pattern is one of four pseudo-random sequences or one of two clock-like patterns. The number of mismatching bits is added to a saturating error total, and every valid word adds one to a saturating word total. Software may clear both totals at any time.

A link flag reports whether the stream is being received cleanly. The flag has five-word hysteresis in each direction. While the flag is low, the local reference predicts each bit from bits already received, so it locks onto any phase of the incoming stream without a shared seed. Once the flag is high, the reference runs on its own. A corrupted bit then shows up as a single error and does not spread into later predictions.

The receive side is a valid/ready stream. `rx_ready` is held high at all times, so the block never applies back-pressure. A word is consumed on every rising edge where `rx_valid` is high. The producer need not wait for `rx_ready`.

Top module: `pattern_checker`

## Requirements
- R1: After reset, `link_up` is 0, `word_cnt` is 0 and `err_cnt` is 0.
- R2: `pat_sel` selects a bit recurrence, with word bit 0 taken as the earliest bit in time:
  - code 0: b[n] = b[n-7] ^ b[n-6]
  - code 1: b[n] = b[n-15] ^ b[n-14]
  - code 2: b[n] = b[n-23] ^ b[n-18]
  - code 3: b[n] = b[n-31] ^ b[n-28]
  - code 4: b[n] = ~b[n-1]
  - code 5: b[n] = ~b[n-10]
  - codes 6 and 7 behave as code 0.
  While `link_up` is 0, each expected bit comes from previously received bits. A single flipped bit at word position 0 under code 0 therefore yields 3 errors, at positions 0, 6 and 7.
- R3: While `link_up` is 1, the reference advances from its own generated bits. A single flipped bit in a word adds exactly 1 to `err_cnt`.
- R4: Each valid word adds 1 to `word_cnt` and adds its number of mismatching bits to `err_cnt`.
- R5: `link_up` rises on the edge that accepts the fifth consecutive error-free valid word seen while it is low.
- R6: `link_up` falls on the edge that accepts the fifth consecutive errored valid word seen while it is high. One clean word in between restarts that run.
- R7: While `link_up` is low, one errored word restarts the clean-word run.
- R8: Edges with `rx_valid` low change neither counter, nor the link flag, nor the reference.
- R9: `stat_clr` zeroes both counters on the next edge. It takes precedence over a valid word in the same cycle and leaves `link_up` untouched.
- R10: Both counters saturate at 2^CNT_W-1 instead of wrapping.
- R11: `rx_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Received word present this cycle |
| rx_ready | output | 1 | Always high; the block never stalls |
| pat_sel | input | 3 | Pattern code, see R2 |
| rx_data | input | W | Received word, bit 0 earliest |
| stat_clr | input | 1 | Clear both statistics counters |
| link_up | output | 1 | Link flag with hysteresis |
| word_cnt | output | CNT_W | Saturating count of valid words |
| err_cnt | output | CNT_W | Saturating count of mismatched bits |

## Verification
The embedded properties assume that `rx_valid`, `stat_clr` and `pat_sel` hold known values from reset onward. They also assume the pattern code is steady within a word, because it is sampled on the same edge as the data. The stimulus drives every input from time zero and changes inputs only on falling clock edges. It switches pattern codes only at word boundaries, and it reseeds its own transmitter whenever it does so. Corner cases covered include lock from an arbitrary phase, single-bit corruption in both link states, a broken run in each direction, clears that collide with valid words, and counters driven to saturation with a narrow counter width.

// File: rtl/pc_pkg.sv
`timescale 1ns/1ps
package pc_pkg;

  localparam int HIST_W = 31;

  typedef enum logic [2:0] {
    PAT_PRBS7  = 3'd0,
    PAT_PRBS15 = 3'd1,
    PAT_PRBS23 = 3'd2,
    PAT_PRBS31 = 3'd3,
    PAT_ALT2   = 3'd4,
    PAT_ALT20  = 3'd5,
    PAT_RSV6   = 3'd6,
    PAT_RSV7   = 3'd7
  } pat_e;

  typedef struct packed {
    logic [4:0] tap_a;
    logic [4:0] tap_b;
    logic       use_b;
    logic       inv;
  } rule_t;

  function automatic rule_t pat_rule(pat_e p);
    rule_t r;
    r.tap_a = 5'd7;
    r.tap_b = 5'd6;
    r.use_b = 1'b1;
    r.inv   = 1'b0;
    case (p)
      PAT_PRBS15: begin r.tap_a = 5'd15; r.tap_b = 5'd14; end
      PAT_PRBS23: begin r.tap_a = 5'd23; r.tap_b = 5'd18; end
      PAT_PRBS31: begin r.tap_a = 5'd31; r.tap_b = 5'd28; end
      PAT_ALT2:   begin r.tap_a = 5'd1;  r.tap_b = 5'd1; r.use_b = 1'b0; r.inv = 1'b1; end
      PAT_ALT20:  begin r.tap_a = 5'd10; r.tap_b = 5'd1; r.use_b = 1'b0; r.inv = 1'b1; end
      default:    begin r.tap_a = 5'd7;  r.tap_b = 5'd6; end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pc_ref_gen.sv
`timescale 1ns/1ps
module pc_ref_gen
  import pc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_i,
  input  logic         locked_i,
  input  rule_t        rule_i,
  input  logic [W-1:0] rx_i,
  output logic [W-1:0] exp_o
);

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;

  // Walk the word in time order: predict, then shift in either the
  // received bit (hunting) or the predicted bit (locked, free-running).
  always_comb begin
    logic [HIST_W-1:0] h;
    logic              pred;
    h     = hist_q;
    exp_o = '0;
    for (int i = 0; i < W; i++) begin
      pred     = h[rule_i.tap_a - 5'd1] ^ (rule_i.use_b & h[rule_i.tap_b - 5'd1]) ^ rule_i.inv;
      exp_o[i] = pred;
      h        = {h[HIST_W-2:0], (locked_i ? pred : rx_i[i])};
    end
    hist_d = h;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else if (adv_i) hist_q <= hist_d;
  end

  // R2: while hunting, the newest history bit is the last received bit
  p_seed_from_rx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !locked_i) |=> hist_q[0] == $past(rx_i[W-1]));

  // R8: no valid word, no reference movement
  p_ref_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(hist_q));

endmodule

// File: rtl/pc_popcount.sv
`timescale 1ns/1ps
module pc_popcount #(
  parameter int W  = 16,
  parameter int OW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [OW-1:0] cnt_o
);

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) begin
      cnt_o = cnt_o + {{(OW-1){1'b0}}, vec_i[i]};
    end
  end

endmodule

// File: rtl/pc_link_mon.sv
`timescale 1ns/1ps
module pc_link_mon #(
  parameter int RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vld_i,
  input  logic clean_i,
  output logic link_o
);

  localparam int RW = $clog2(RUN + 1);
  localparam logic [RW-1:0] LAST = RW'(RUN - 1);

  logic [RW-1:0] good_q;
  logic [RW-1:0] bad_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_o <= 1'b0;
      good_q <= '0;
      bad_q  <= '0;
    end else if (vld_i) begin
      if (clean_i) begin
        bad_q <= '0;
        if (!link_o) begin
          if (good_q == LAST) begin
            link_o <= 1'b1;
            good_q <= '0;
          end else begin
            good_q <= good_q + 1'b1;
          end
        end
      end else begin
        good_q <= '0;
        if (link_o) begin
          if (bad_q == LAST) begin
            link_o <= 1'b0;
            bad_q  <= '0;
          end else begin
            bad_q <= bad_q + 1'b1;
          end
        end
      end
    end
  end

  p_rise_on_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_o) |-> $past(vld_i && clean_i));

  p_fall_on_error_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_o) |-> $past(vld_i && !clean_i));

  p_link_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> $stable(link_o));

endmodule

// File: rtl/pc_sat_cnt.sv
`timescale 1ns/1ps
module pc_sat_cnt #(
  parameter int CNT_W = 32,
  parameter int INC_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W:0] sum;

  assign sum = {1'b0, cnt_o} + {{(CNT_W+1-INC_W){1'b0}}, inc_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (en_i)   cnt_o <= sum[CNT_W] ? TOP : sum[CNT_W-1:0];
  end

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> cnt_o == '0);

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == TOP && !clr_i) |=> cnt_o == TOP);

  p_monotone_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> cnt_o >= $past(cnt_o));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !en_i) |=> $stable(cnt_o));

endmodule

// File: rtl/pattern_checker.sv
`timescale 1ns/1ps
module pattern_checker
  import pc_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = 32,
  parameter int RUN   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [2:0]       pat_sel,
  input  logic [W-1:0]     rx_data,
  input  logic             stat_clr,
  output logic             link_up,
  output logic [CNT_W-1:0] word_cnt,
  output logic [CNT_W-1:0] err_cnt
);

  localparam int PW = $clog2(W + 1);

  rule_t        rule;
  logic [W-1:0] exp_word;
  logic [W-1:0] diff;
  logic [PW-1:0] nerr;
  logic         clean;

  assign rx_ready = 1'b1;
  assign rule     = pat_rule(pat_e'(pat_sel));
  assign diff     = exp_word ^ rx_data;
  assign clean    = (nerr == '0);

  pc_ref_gen #(.W(W)) u_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_i    (rx_valid),
    .locked_i (link_up),
    .rule_i   (rule),
    .rx_i     (rx_data),
    .exp_o    (exp_word)
  );

  pc_popcount #(.W(W), .OW(PW)) u_pop (
    .vec_i (diff),
    .cnt_o (nerr)
  );

  pc_link_mon #(.RUN(RUN)) u_link (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld_i   (rx_valid),
    .clean_i (clean),
    .link_o  (link_up)
  );

  pc_sat_cnt #(.CNT_W(CNT_W), .INC_W(1)) u_words (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (stat_clr),
    .en_i  (rx_valid),
    .inc_i (1'b1),
    .cnt_o (word_cnt)
  );

  pc_sat_cnt #(.CNT_W(CNT_W), .INC_W(PW)) u_errs (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (stat_clr),
    .en_i  (rx_valid),
    .inc_i (nerr),
    .cnt_o (err_cnt)
  );

  // R9: a clear never disturbs the link flag by itself
  p_clr_keeps_link_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !rx_valid) |=> $stable(link_up));

endmodule

// File: tb/sim_pattern_checker.sv
`timescale 1ns/1ps
module sim_pattern_checker;

  localparam int W     = 16;
  localparam int CNT_W = 8;
  localparam int MAXC  = 255;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rx_valid = 1'b0;
  logic             rx_ready;
  logic [2:0]       pat_sel = 3'd0;
  logic [W-1:0]     rx_data = '0;
  logic             stat_clr = 1'b0;
  logic             link_up;
  logic [CNT_W-1:0] word_cnt;
  logic [CNT_W-1:0] err_cnt;

  int n_chk = 0;
  int n_fail = 0;

  bit [30:0] mh = '0;
  bit        ml = 0;
  int        mg = 0, mb = 0, mw = 0, me = 0;
  bit [30:0] th = 31'h1;

  always #2.5 clk = ~clk;

  pattern_checker #(.W(W), .CNT_W(CNT_W), .RUN(5)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .pat_sel(pat_sel), .rx_data(rx_data), .stat_clr(stat_clr),
    .link_up(link_up), .word_cnt(word_cnt), .err_cnt(err_cnt)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic rule_of(input int sel, output int a, output int b, output bit inv);
    a = 7; b = 6; inv = 0;
    case (sel)
      1: begin a = 15; b = 14; end
      2: begin a = 23; b = 18; end
      3: begin a = 31; b = 28; end
      4: begin a = 1;  b = 0; inv = 1; end
      5: begin a = 10; b = 0; inv = 1; end
      default: begin a = 7; b = 6; end
    endcase
  endtask

  task automatic tx_word(input int sel, output logic [W-1:0] w);
    int a, b; bit inv; bit g;
    rule_of(sel, a, b, inv);
    for (int i = 0; i < W; i++) begin
      g = th[a-1] ^ ((b > 0) ? th[b-1] : 1'b0) ^ inv;
      w[i] = g;
      th = {th[29:0], g};
    end
  endtask

  task automatic model_step(input bit v, input bit c, input int sel, input logic [W-1:0] d);
    int a, b; bit inv; bit p; bit [30:0] h; logic [W-1:0] ex; int e;
    rule_of(sel, a, b, inv);
    e = 0;
    if (v) begin
      h = mh;
      for (int i = 0; i < W; i++) begin
        p = h[a-1] ^ ((b > 0) ? h[b-1] : 1'b0) ^ inv;
        ex[i] = p;
        h = {h[29:0], (ml ? p : d[i])};
      end
      mh = h;
      e = $countones(ex ^ d);
      if (e == 0) begin
        mb = 0;
        if (!ml) begin
          if (mg == 4) begin ml = 1; mg = 0; end else mg++;
        end
      end else begin
        mg = 0;
        if (ml) begin
          if (mb == 4) begin ml = 0; mb = 0; end else mb++;
        end
      end
    end
    if (c) begin mw = 0; me = 0; end
    else if (v) begin
      mw = (mw + 1 > MAXC) ? MAXC : mw + 1;
      me = (me + e > MAXC) ? MAXC : me + e;
    end
  endtask

  task automatic send(input bit v, input bit c, input int sel, input logic [W-1:0] d);
    @(negedge clk);
    rx_valid = v; stat_clr = c; pat_sel = 3'(sel); rx_data = d;
    model_step(v, c, sel, d);
    @(posedge clk);
    #1;
    rx_valid = 0; stat_clr = 0;
    chk("R5 R6 R7 link vs model", link_up, ml);
    chk("R4 word_cnt vs model", word_cnt, mw);
    chk("R4 R2 err_cnt vs model", err_cnt, me);
  endtask

  task automatic send_pat(input int sel, input logic [W-1:0] mask);
    logic [W-1:0] w;
    tx_word(sel, w);
    send(1, 0, sel, w ^ mask);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int r; int e0; int sel; logic [W-1:0] m; logic [W-1:0] w; int lk;
    r = $urandom(32'd9127);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    // R1 / R11
    chk("R1 link after reset", link_up, 0);
    chk("R1 word_cnt after reset", word_cnt, 0);
    chk("R1 err_cnt after reset", err_cnt, 0);
    chk("R11 ready high", rx_ready, 1);

    // R5 / R2: lock onto pattern code 0 from an arbitrary phase
    th = 31'($urandom) | 31'h1;
    for (int k = 0; k < 12; k++) send_pat(0, '0);
    chk("R5 link up after clean run", link_up, 1);

    // R3: one flipped bit while locked counts once
    e0 = int'(err_cnt);
    send_pat(0, 16'h0008);
    chk("R3 single error while locked", err_cnt, e0 + 1);

    // R6: three more errored, one clean, then five errored
    for (int k = 0; k < 3; k++) send_pat(0, 16'h0008);
    chk("R6 link holds after four errored", link_up, 1);
    send_pat(0, '0);
    for (int k = 0; k < 4; k++) send_pat(0, 16'h0008);
    chk("R6 run restarted by clean word", link_up, 1);
    send_pat(0, 16'h0008);
    chk("R6 link falls on fifth errored", link_up, 0);

    // R2 / R7: hunting mode, error spread and broken clean run
    for (int k = 0; k < 4; k++) send_pat(0, '0);
    chk("R7 link still low after four clean", link_up, 0);
    e0 = int'(err_cnt);
    send_pat(0, 16'h0001);
    chk("R2 flipped bit0 spreads to three while hunting", err_cnt, e0 + 3);
    for (int k = 0; k < 4; k++) send_pat(0, '0);
    chk("R7 run restarted, still low", link_up, 0);
    send_pat(0, '0);
    chk("R7 link up on fifth clean", link_up, 1);

    // R8: idle cycles with garbage data change nothing
    e0 = int'(err_cnt); lk = int'(word_cnt);
    for (int k = 0; k < 5; k++) send(0, 0, 3, 16'($urandom));
    chk("R8 err_cnt idle", err_cnt, e0);
    chk("R8 word_cnt idle", word_cnt, lk);
    chk("R8 link idle", link_up, 1);
    send_pat(0, '0);
    chk("R8 reference did not move on idle", err_cnt, e0);

    // R9: clear together with a valid errored word
    tx_word(0, w);
    send(1, 1, 0, w ^ 16'h00f0);
    chk("R9 word_cnt cleared", word_cnt, 0);
    chk("R9 err_cnt cleared", err_cnt, 0);
    chk("R9 link untouched by clear", link_up, 1);

    // R2: clock patterns
    th = 31'($urandom);
    for (int k = 0; k < 10; k++) send_pat(4, '0);
    chk("R2 alternating pattern locked", link_up, 1);
    th = 31'($urandom);
    for (int k = 0; k < 14; k++) send_pat(5, '0);
    chk("R2 ten-ones-ten-zeros locked", link_up, 1);

    // R10: saturation of both counters
    send(0, 1, 1, '0);
    th = 31'($urandom) | 31'h1;
    for (int k = 0; k < 300; k++) send_pat(1, '0);
    chk("R10 word_cnt saturates", word_cnt, MAXC);
    for (int k = 0; k < 40; k++) send(1, 0, 1, 16'($urandom));
    chk("R10 err_cnt saturates", err_cnt, MAXC);
    chk("R10 word_cnt stays saturated", word_cnt, MAXC);

    // Random mix
    sel = 3;
    for (int k = 0; k < 3000; k++) begin
      if (k % 150 == 0) begin
        sel = int'($urandom % 8);
        th = 31'($urandom) | 31'h1;
      end
      if ($urandom % 100 == 0) send(0, 1, sel, '0);
      else if ($urandom % 4 == 0) send(0, 0, sel, 16'($urandom));
      else begin
        m = '0;
        if ($urandom % 10 == 0) m[$urandom % W] = 1'b1;
        send_pat(sel, m);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule